// File: doc/BRIEF.md
# GPIO Output/Input Data Register Bank

This block is the data half of a 32-pin general-purpose I/O port. It holds the latch that drives the output pins and lets software read back the synchronized levels of the input pins. Software reaches it over a simple single-cycle register bus. A request is a `valid` pulse with a write flag, a byte address and write data. Read data comes back, registered, on the cycle after the request.

Besides the directly writable output register, three write-only mask registers change chosen output bits in one bus write, with no read-modify-write:

- The set mask forces selected bits to 1.
- The clear mask forces selected bits to 0.
- The toggle mask inverts selected bits.

Input pins pass through a two-stage flop synchronizer before software can see them. Pin direction, interrupts and pad settings belong to other blocks.

Top module: `gpio_data_bank`

## Requirements
- R1: A synchronous active-high reset drives every bit of `pins_out` and `bus_rdata` to 0.
- R2: A write to offset 0x00 loads all 32 bits of the output latch from `bus_wdata`. A read of offset 0x00 returns the latch.
- R3: A write to offset 0x04 sets each output bit whose `bus_wdata` bit is 1 and leaves the others unchanged. An all-zero mask changes nothing.
- R4: A write to offset 0x08 clears each output bit whose `bus_wdata` bit is 1 and leaves the others unchanged.
- R5: A write to offset 0x0C inverts each output bit whose `bus_wdata` bit is 1 and leaves the others unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return 0.
- R7: A read of offset 0x10 returns `pins_in` through a two-flop synchronizer. After `pins_in` changes, a read accepted on the second rising edge still returns the old level. A read accepted on the third rising edge returns the new level.
- R8: A read of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns 0. A write to such an offset leaves `pins_out` unchanged.
- R9: A read accepted on a rising edge places its data on `bus_rdata` right after that same edge. After any edge that accepts no read (idle or write), `bus_rdata` is 0.
- R10: The output latch changes only on a write with `bus_valid` high. With `bus_valid` low, a write flag, address and data have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request strobe, one request per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| pins_in | input | 32 | Asynchronous input pin levels |
| pins_out | output | 32 | Output latch driving the pins |

## Verification
The hardest behaviour to pin down from the ports is the exact depth of the input synchronizer. A read returns only what the second flop held before the edge, so an off-by-one stage count gives the same final data.

The bench changes `pins_in` while the bus is idle. It then issues one read at the second edge after the change and expects the old value. A read at the third edge must return the new value.

A table of mixed writes and reads also chains set, clear and toggle masks over a running latch value. Each atomic operation is therefore checked against bits that were set by a different operation.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register offsets; software depends on this layout.
  localparam int unsigned OFS_DATA = 32'h00;
  localparam int unsigned OFS_SET  = 32'h04;
  localparam int unsigned OFS_CLR  = 32'h08;
  localparam int unsigned OFS_TGL  = 32'h0C;
  localparam int unsigned OFS_PIN  = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DATA = 3'd1,
    SEL_SET  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_TGL  = 3'd4,
    SEL_PIN  = 3'd5
  } reg_sel_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              ld_en,
  output logic              set_en,
  output logic              clr_en,
  output logic              tgl_en,
  output logic              rd_en
);

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
    else if (bus_addr == ADDR_W'(OFS_SET))  sel = SEL_SET;
    else if (bus_addr == ADDR_W'(OFS_CLR))  sel = SEL_CLR;
    else if (bus_addr == ADDR_W'(OFS_TGL))  sel = SEL_TGL;
    else if (bus_addr == ADDR_W'(OFS_PIN))  sel = SEL_PIN;
    else                                    sel = SEL_NONE;
  end

  logic wr_req;
  assign wr_req = bus_valid && bus_write;
  assign rd_en  = bus_valid && !bus_write;
  assign ld_en  = wr_req && (sel == SEL_DATA);
  assign set_en = wr_req && (sel == SEL_SET);
  assign clr_en = wr_req && (sel == SEL_CLR);
  assign tgl_en = wr_req && (sel == SEL_TGL);

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             tgl_en,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (ld_en)  q <= mask;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
    else if (tgl_en) q <= q ^ mask;
  end

  // R3: set touches only masked bits
  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    set_en |=> q == ($past(q) | $past(mask)));

  // R4: clear touches only masked bits
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> q == ($past(q) & ~$past(mask)));

  // R5: toggle inverts only masked bits
  a_r5_tgl_bits: assert property (@(posedge clk) disable iff (rst)
    tgl_en |=> q == ($past(q) ^ $past(mask)));

  // R10: without a write strobe the latch holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !(ld_en || set_en || clr_en || tgl_en) |=> $stable(q));

  // R8: the decoder never raises two strobes at once
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_en, set_en, clr_en, tgl_en}));

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

  generate
    if (STAGES >= 2) begin : g_chk
      // R7: the last stage follows the one before it by one cycle
      a_r7_sync_shift: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage[STAGES-1] == $past(stage[STAGES-2]));
    end
  endgenerate

endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pins_in,
  output logic [PINS-1:0]   pins_out
);

  reg_sel_e        sel;
  logic            ld_en, set_en, clr_en, tgl_en, rd_en;
  logic [PINS-1:0] pins_sync;
  logic [PINS-1:0] rd_mux;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .sel       (sel),
    .ld_en     (ld_en),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .tgl_en    (tgl_en),
    .rd_en     (rd_en)
  );

  gpio_out_latch #(.WIDTH(PINS)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ld_en),
    .set_en (set_en),
    .clr_en (clr_en),
    .tgl_en (tgl_en),
    .mask   (bus_wdata),
    .q      (pins_out)
  );

  gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_in),
    .q   (pins_sync)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = pins_out;
      SEL_PIN:  rd_mux = pins_sync;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  // R9: any edge without a read leaves zero on the read bus
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> bus_rdata == '0);

  // R2: a read of the data register returns the latch as it was
  a_r2_read_data: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_DATA))
      |=> bus_rdata == $past(pins_out));

  // R8: a write to an unmapped offset leaves the pins alone
  a_r8_unmapped_wr: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr != ADDR_W'(OFS_DATA)
      && bus_addr != ADDR_W'(OFS_SET) && bus_addr != ADDR_W'(OFS_CLR)
      && bus_addr != ADDR_W'(OFS_TGL)) |=> $stable(pins_out));

endmodule

// File: tb/gpio_data_bank_bench.sv
module gpio_data_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp_out;
    logic [31:0] exp_rd;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] PINS_A = 32'h3C3C_C3C3;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'h0, 8'd2},  // R2 load
    '{1'b0, 8'h00, 32'h0,         32'hA5A5_0F0F, 32'hA5A5_0F0F, 8'd2},
    '{1'b1, 8'h04, 32'h0000_F0F0, 32'hA5A5_FFFF, 32'h0, 8'd3},  // R3 set
    '{1'b1, 8'h08, 32'hA000_000F, 32'h05A5_FFF0, 32'h0, 8'd4},  // R4 clear
    '{1'b1, 8'h0C, 32'hFFFF_0000, 32'hFA5A_FFF0, 32'h0, 8'd5},  // R5 toggle
    '{1'b0, 8'h04, 32'h0,         32'hFA5A_FFF0, 32'h0, 8'd6},  // R6
    '{1'b0, 8'h08, 32'h0,         32'hFA5A_FFF0, 32'h0, 8'd6},
    '{1'b0, 8'h0C, 32'h0,         32'hFA5A_FFF0, 32'h0, 8'd6},
    '{1'b1, 8'h14, 32'h1234_5678, 32'hFA5A_FFF0, 32'h0, 8'd8},  // R8
    '{1'b0, 8'h14, 32'h0,         32'hFA5A_FFF0, 32'h0, 8'd8},
    '{1'b0, 8'h40, 32'h0,         32'hFA5A_FFF0, 32'h0, 8'd8},
    '{1'b1, 8'h0C, 32'h0000_000F, 32'hFA5A_FFFF, 32'h0, 8'd5},
    '{1'b0, 8'h00, 32'h0,         32'hFA5A_FFFF, 32'hFA5A_FFFF, 8'd2},
    '{1'b1, 8'h04, 32'h0,         32'hFA5A_FFFF, 32'h0, 8'd3},  // R3 empty mask
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'hFA5A_FFFF, 32'h0, 8'd8},  // write to input reg
    '{1'b0, 8'h10, 32'h0,         32'hFA5A_FFFF, PINS_A, 8'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins_in = '0;
  logic [31:0] pins_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_data_bank u_gpio_data_bank (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_in   (pins_in),
    .pins_out  (pins_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic v, input logic w, input logic [7:0] a,
                      input logic [31:0] d);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pins_out in reset", pins_out, 32'h0);
    check("R1", "rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;

    // R7: synchronizer depth, pins changed with the bus idle
    pins_in = 32'hDEAD_BEEF;
    step(1'b0, 1'b0, 8'h00, 32'h0);
    step(1'b1, 1'b0, 8'h10, 32'h0);
    check("R7", "read at second edge still old", bus_rdata, 32'h0);
    step(1'b1, 1'b0, 8'h10, 32'h0);
    check("R7", "read at third edge is new", bus_rdata, 32'hDEAD_BEEF);
    pins_in = PINS_A;
    repeat (3) step(1'b0, 1'b0, 8'h00, 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].wd);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d pins_out", i),
            pins_out, VECS[i].exp_out);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rdata", i),
            bus_rdata, VECS[i].exp_rd);
    end

    // R9: data after a read returns to zero on an idle edge
    step(1'b1, 1'b0, 8'h00, 32'h0);
    check("R9", "read data present", bus_rdata, 32'hFA5A_FFFF);
    step(1'b0, 1'b0, 8'h00, 32'h0);
    check("R9", "idle edge clears rdata", bus_rdata, 32'h0);

    // R10: write fields with valid low have no effect
    step(1'b0, 1'b1, 8'h00, 32'h0000_0000);
    check("R10", "valid low data write", pins_out, 32'hFA5A_FFFF);
    step(1'b0, 1'b1, 8'h08, 32'hFFFF_FFFF);
    check("R10", "valid low clear write", pins_out, 32'hFA5A_FFFF);

    // R4 with a full mask, then R3 with a full mask
    step(1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF);
    check("R4", "clear all", pins_out, 32'h0);
    step(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF);
    check("R3", "set all", pins_out, 32'hFFFF_FFFF);

    // R1: reset in the middle of a run
    rst = 1'b1;
    step(1'b0, 1'b0, 8'h00, 32'h0);
    check("R1", "mid-run reset clears latch", pins_out, 32'h0);
    rst = 1'b0;
    step(1'b1, 1'b0, 8'h00, 32'h0);
    check("R1", "latch reads zero after reset", bus_rdata, 32'h0);

    finish_run();
  end

endmodule